// File: doc/BRIEF.md
# Rate-Matching Receive Elastic Buffer

This block sits behind the character decoder of one byte-wide serial receive channel. Each decoded character is written with three status flags: an IDLE marker, a control-character marker and a code-error marker. It is written on the channel's recovered clock and read out on a separately chosen output clock. The storage is a 16-entry ring. Write and read pointers cross between the two clock domains in Gray code through two-flop synchronizers.

The two clocks need not be frequency-locked. The read side stretches the stream by presenting the IDLE at its head a second time when the buffer runs low. The write side shrinks the stream by not storing an incoming IDLE when the buffer runs high. Three events recenter the buffer to half full: the asynchronous active-low reset, a comma that moved the character framing boundary, and the synchronization point of the word-sync sequence. Characters may be lost or repeated across a recenter. If rate matching cannot keep up and the ring empties or fills, a sticky error flag rises in the output domain and holds until the next recenter.

Top module: `elastic_rx_buffer`

## Requirements
- R1: While reset is active and just after it, the output shows the filler character (IDLE flag 1, control flag 1, error flag 0, data 8'hBC) and `fifo_err` is 0. Reset leaves the ring half full of filler, so with equal clocks a character written after reset reaches the output about DEPTH/2 output-clock cycles later.
- R2: With equal clock rates, every non-IDLE character comes out once, in order, with its data byte and its control and error flags unchanged.
- R3: When the output clock is faster, an extra IDLE is presented only when the read-side fill is below LO_THR (4) and the character at the read point is an IDLE. No non-IDLE character is lost or repeated, and `fifo_err` stays 0.
- R4: When the recovered clock is faster, an incoming IDLE is discarded only when the write-side fill is above HI_THR (12). No non-IDLE character is lost, and `fifo_err` stays 0.
- R5: A one-cycle pulse on `comma_realign` (recovered-clock domain) recenters the read pointer to half depth behind the write pointer and clears `fifo_err`.
- R6: A one-cycle pulse on `wsync_point` (recovered-clock domain) has the same recentering and error-clearing effect as R5.
- R7: If the read side finds the ring empty, it holds its pointer, outputs the filler character, and sets `fifo_err`. The flag stays set until a recenter.
- R8: If the write side finds the ring full on a character it would store, it drops the character and reports an overflow. After synchronization this sets `fifo_err`, which holds until a recenter. Overflow reports are suppressed for BLANK cycles after a recenter trigger.
- R9: When a recenter pulse and an empty or overflow event reach the read side in the same cycle, the recenter wins and `fifo_err` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Recovered (write) clock |
| rclk | input | 1 | Output (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset; recenters the ring |
| wr_data | input | 8 | Decoded character byte |
| wr_idle | input | 1 | Character is an IDLE |
| wr_kchar | input | 1 | Character is a control character |
| wr_cerr | input | 1 | Character had a decode error |
| comma_realign | input | 1 | Pulse: comma moved the framing boundary |
| wsync_point | input | 1 | Pulse: word-sync synchronization point seen |
| rd_data | output | 8 | Output character byte |
| rd_idle | output | 1 | Output IDLE flag |
| rd_kchar | output | 1 | Output control-character flag |
| rd_cerr | output | 1 | Output decode-error flag |
| fifo_err | output | 1 | Sticky underflow/overflow flag, cleared by recenter |

## Verification
A recenter request can reach the read side in the same cycle as an empty-ring event, because the ring stays empty for many cycles in a row once underflow has begun. The bench provokes this case. It drains the ring with an IDLE-free stream on a faster output clock until `fifo_err` rises. It confirms the flag is still set a while later, then pulses `comma_realign` while the drain is still under way. The verdict is that `fifo_err` is 0 soon after the pulse and stays 0 once IDLE-bearing traffic resumes. The same sequence runs on the overflow side, with `wsync_point` as the trigger.

// File: rtl/elb_pkg.sv
`timescale 1ns/1ps
package elb_pkg;
  typedef struct packed {
    logic       idle;
    logic       kchar;
    logic       cerr;
    logic [7:0] data;
  } elb_char_t;

  // Filler written into every slot at reset and shown on an empty read.
  localparam elb_char_t FILL_CHAR = '{idle: 1'b1, kchar: 1'b1, cerr: 1'b0, data: 8'hBC};
endpackage

// File: rtl/elb_sync.sv
`timescale 1ns/1ps
module elb_sync #(
  parameter int           W       = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/elb_pulse_xfer.sv
`timescale 1ns/1ps
module elb_pulse_xfer (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse
);
  logic src_tgl;
  logic [2:0] dst_sh;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) src_tgl <= 1'b0;
    else if (src_pulse) src_tgl <= ~src_tgl;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) dst_sh <= '0;
    else dst_sh <= {dst_sh[1:0], src_tgl};
  end

  assign dst_pulse = dst_sh[2] ^ dst_sh[1];
endmodule

// File: rtl/elb_wr.sv
`timescale 1ns/1ps
module elb_wr
  import elb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int HI_THR = 12,
  parameter int BLANK  = 8
) (
  input  logic                     wclk,
  input  logic                     rst_n,
  input  elb_char_t                wr_char,
  input  logic                     rc_req,
  input  logic [$clog2(DEPTH):0]   rgray_sync,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output elb_char_t                head_char,
  output logic [$clog2(DEPTH):0]   wgray_q,
  output logic                     ovf_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int BW = $clog2(BLANK + 1);
  localparam logic [PW-1:0] HI_LVL   = PW'(HI_THR);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  elb_char_t     ring [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_seen, wfill;
  logic [BW-1:0] blank_q;
  logic          del_ev, full_ev, put_ev;

  assign rptr_seen = from_gray(rgray_sync);
  assign wfill     = wptr_q - rptr_seen;
  assign del_ev    = wr_char.idle && (wfill > HI_LVL);
  assign full_ev   = !del_ev && (wfill >= FULL_LVL);
  assign put_ev    = !del_ev && !full_ev;
  assign ovf_pulse = full_ev && (blank_q == '0);
  assign wptr_d    = put_ev ? wptr_q + 1'b1 : wptr_q;
  assign head_char = ring[rd_addr];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= FILL_CHAR;
      wptr_q  <= '0;
      wgray_q <= '0;
      blank_q <= '0;
    end else begin
      if (put_ev) ring[wptr_q[AW-1:0]] <= wr_char;
      wptr_q  <= wptr_d;
      wgray_q <= to_gray(wptr_d);
      if (rc_req) blank_q <= BW'(BLANK);
      else if (blank_q != '0) blank_q <= blank_q - 1'b1;
    end
  end

  AST_DEL_NO_ADVANCE: assert property (@(posedge wclk) disable iff (!rst_n)
    del_ev |=> wptr_q == $past(wptr_q)); // R4
  AST_FULL_NO_ADVANCE: assert property (@(posedge wclk) disable iff (!rst_n)
    full_ev |=> wptr_q == $past(wptr_q)); // R8
endmodule

// File: rtl/elb_rd.sv
`timescale 1ns/1ps
module elb_rd
  import elb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LO_THR = 4
) (
  input  logic                     rclk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH):0]   wgray_sync,
  input  elb_char_t                head_char,
  input  logic                     rc_pulse,
  input  logic                     ovf_pulse,
  output logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [$clog2(DEPTH):0]   rgray_q,
  output elb_char_t                out_q,
  output logic                     fifo_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LO_LVL   = PW'(LO_THR);
  localparam logic [PW-1:0] PTR_INIT = PW'(2 * DEPTH - DEPTH / 2);
  localparam logic [PW-1:0] GRY_INIT = PTR_INIT ^ (PTR_INIT >> 1);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rptr_q, rptr_d, wptr_seen, rfill;
  logic          uf_ev, ins_ev, adv_ev;

  assign wptr_seen = from_gray(wgray_sync);
  assign rfill     = wptr_seen - rptr_q;
  assign uf_ev     = !rc_pulse && (rfill == '0);
  assign ins_ev    = !rc_pulse && !uf_ev && (rfill < LO_LVL) && head_char.idle;
  assign adv_ev    = !rc_pulse && !uf_ev && !ins_ev;
  assign rptr_d    = rc_pulse ? wptr_seen - HALF_LVL :
                     adv_ev   ? rptr_q + 1'b1 : rptr_q;
  assign rd_addr   = rptr_q[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q   <= PTR_INIT;
      rgray_q  <= GRY_INIT;
      out_q    <= FILL_CHAR;
      fifo_err <= 1'b0;
    end else begin
      rptr_q  <= rptr_d;
      rgray_q <= to_gray(rptr_d);
      out_q   <= uf_ev ? FILL_CHAR : head_char;
      if (rc_pulse) fifo_err <= 1'b0;
      else if (uf_ev || ovf_pulse) fifo_err <= 1'b1;
    end
  end

  AST_INSERT_SHOWS_IDLE: assert property (@(posedge rclk) disable iff (!rst_n)
    ins_ev |=> out_q.idle); // R3
  AST_EMPTY_SETS_ERR: assert property (@(posedge rclk) disable iff (!rst_n)
    uf_ev |=> fifo_err); // R7
  AST_ERR_STICKY: assert property (@(posedge rclk) disable iff (!rst_n)
    (fifo_err && !rc_pulse) |=> fifo_err); // R7
  AST_RECENTER_WINS: assert property (@(posedge rclk) disable iff (!rst_n)
    rc_pulse |=> !fifo_err); // R9
  AST_FILL_IN_RANGE: assert property (@(posedge rclk) disable iff (!rst_n)
    rfill <= PW'(DEPTH)); // R8
endmodule

// File: rtl/elastic_rx_buffer.sv
`timescale 1ns/1ps
module elastic_rx_buffer
  import elb_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LO_THR = 4,
  parameter int HI_THR = 12,
  parameter int BLANK  = 8
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic [7:0] wr_data,
  input  logic       wr_idle,
  input  logic       wr_kchar,
  input  logic       wr_cerr,
  input  logic       comma_realign,
  input  logic       wsync_point,
  output logic [7:0] rd_data,
  output logic       rd_idle,
  output logic       rd_kchar,
  output logic       rd_cerr,
  output logic       fifo_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] RPTR_INIT = PW'(2 * DEPTH - DEPTH / 2);
  localparam logic [PW-1:0] RGRY_INIT = RPTR_INIT ^ (RPTR_INIT >> 1);

  elb_char_t     wr_char, head_char, out_char;
  logic [PW-1:0] wgray, wgray_r, rgray, rgray_w;
  logic [AW-1:0] rd_addr;
  logic          rc_w, rc_r, ovf_w, ovf_r;

  assign wr_char = '{idle: wr_idle, kchar: wr_kchar, cerr: wr_cerr, data: wr_data};
  assign rc_w    = comma_realign | wsync_point;

  elb_wr #(.DEPTH(DEPTH), .HI_THR(HI_THR), .BLANK(BLANK)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_char(wr_char), .rc_req(rc_w),
    .rgray_sync(rgray_w), .rd_addr(rd_addr), .head_char(head_char),
    .wgray_q(wgray), .ovf_pulse(ovf_w));

  elb_sync #(.W(PW), .RST_VAL('0)) u_wsync (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  elb_sync #(.W(PW), .RST_VAL(RGRY_INIT)) u_rsync (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

  elb_pulse_xfer u_rc_xfer (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n), .src_pulse(rc_w), .dst_pulse(rc_r));

  elb_pulse_xfer u_ovf_xfer (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n), .src_pulse(ovf_w), .dst_pulse(ovf_r));

  elb_rd #(.DEPTH(DEPTH), .LO_THR(LO_THR)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .wgray_sync(wgray_r), .head_char(head_char),
    .rc_pulse(rc_r), .ovf_pulse(ovf_r), .rd_addr(rd_addr), .rgray_q(rgray),
    .out_q(out_char), .fifo_err(fifo_err));

  assign rd_data  = out_char.data;
  assign rd_idle  = out_char.idle;
  assign rd_kchar = out_char.kchar;
  assign rd_cerr  = out_char.cerr;
endmodule

// File: tb/elastic_rx_buffer_tb.sv
`timescale 1ns/1ps
module elastic_rx_buffer_tb;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [7:0] wr_data = 8'hBC;
  logic       wr_idle = 1'b1, wr_kchar = 1'b1, wr_cerr = 1'b0;
  logic       comma_realign = 1'b0, wsync_point = 1'b0;
  logic [7:0] rd_data;
  logic       rd_idle, rd_kchar, rd_cerr, fifo_err;

  real rhalf = 2.0;
  int  checks = 0, errors = 0;
  int  seq_i = 0, pat = 0, rcyc = 0, got_n = 0, first_cyc = -1;
  bit  rec_on = 1'b0;
  logic [9:0] got [4096];

  elastic_rx_buffer u_dut (.*);

  always #2 wclk = ~wclk;
  initial begin
    #1.3;
    forever #(rhalf) rclk = ~rclk;
  end

  always @(negedge rclk) begin
    rcyc++;
    if (rec_on && !rd_idle) begin
      if (got_n == 0) first_cyc = rcyc;
      if (got_n < 4096) got[got_n] = {rd_kchar, rd_cerr, rd_data};
      got_n++;
    end
  end

  function automatic logic [9:0] exp_char(input int i);
    return {(i % 5) == 0, (i % 7) == 0, i[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    wr_data = 8'hBC; wr_idle = 1'b1; wr_kchar = 1'b1; wr_cerr = 1'b0;
  endtask

  task automatic do_reset(input real half);
    rhalf = half;
    rst_n = 1'b0;
    drive_idle();
    repeat (5) @(negedge wclk);
    rst_n = 1'b1;
    pat = 0;
  endtask

  task automatic idles(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge wclk);
      drive_idle();
    end
  endtask

  // trig: 0 none, 1 comma_realign, 2 wsync_point on the first slot
  task automatic send(input int n, input bit with_idles, input int trig);
    for (int j = 0; j < n; j++) begin
      @(negedge wclk);
      comma_realign = (trig == 1) && (j == 0);
      wsync_point   = (trig == 2) && (j == 0);
      if (with_idles && (pat % 8) >= 6) drive_idle();
      else begin
        {wr_kchar, wr_cerr, wr_data} = exp_char(seq_i);
        wr_idle = 1'b0;
        seq_i++;
      end
      pat++;
    end
    @(negedge wclk);
    comma_realign = 1'b0;
    wsync_point   = 1'b0;
    drive_idle();
  endtask

  task automatic check_seq(input string req, input int start, input int count);
    int bad = -1;
    chk(got_n == count, req, "non-idle output count", got_n, count);
    for (int p = 0; p < count && p < got_n && p < 4096; p++)
      if (bad < 0 && got[p] !== exp_char(start + p)) bad = p;
    chk(bad < 0, req, "first mismatching char (value)", (bad < 0) ? 0 : int'(got[bad]),
        (bad < 0) ? 0 : int'(exp_char(start + bad)));
  endtask

  task automatic t_reset_state();
    do_reset(2.0);
    repeat (2) @(negedge rclk);
    chk(rd_idle === 1'b1, "R1", "rd_idle after reset", rd_idle, 1);
    chk(rd_kchar === 1'b1, "R1", "rd_kchar after reset", rd_kchar, 1);
    chk(rd_data === 8'hBC, "R1", "rd_data after reset", rd_data, 8'hBC);
    chk(fifo_err === 1'b0, "R1", "fifo_err after reset", fifo_err, 0);
  endtask

  task automatic t_order();
    int start, t0;
    do_reset(2.0);
    idles(20);
    got_n = 0; first_cyc = -1; rec_on = 1'b1;
    start = seq_i; t0 = rcyc;
    send(64, 1'b1, 0);
    idles(40);
    rec_on = 1'b0;
    check_seq("R2", start, 48);
    chk((first_cyc - t0) >= HALF && (first_cyc - t0) <= HALF + 4, "R1",
        "latency of first char in read cycles", first_cyc - t0, HALF + 2);
    chk(fifo_err === 1'b0, "R2", "fifo_err at equal rates", fifo_err, 0);
  endtask

  task automatic t_rate(input real half, input string req);
    int start;
    do_reset(half);
    idles(20);
    got_n = 0; rec_on = 1'b1;
    start = seq_i;
    send(480, 1'b1, 0);
    idles(60);
    rec_on = 1'b0;
    check_seq(req, start, 360);
    chk(fifo_err === 1'b0, req, "fifo_err with rate matching", fifo_err, 0);
  endtask

  task automatic t_fault(input real half, input int trig, input string req_err, input string req_rc);
    do_reset(half);
    idles(20);
    send(200, 1'b0, 0);
    @(negedge rclk);
    chk(fifo_err === 1'b1, req_err, "fifo_err after ring fault", fifo_err, 1);
    send(40, 1'b0, 0);
    @(negedge rclk);
    chk(fifo_err === 1'b1, req_err, "fifo_err still held (sticky)", fifo_err, 1);
    send(30, 1'b1, trig);
    @(negedge rclk);
    chk(fifo_err === 1'b0, req_rc, "fifo_err after recenter (R9 recenter wins)", fifo_err, 0);
    send(200, 1'b1, 0);
    @(negedge rclk);
    chk(fifo_err === 1'b0, req_rc, "fifo_err after traffic resumes", fifo_err, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();            // R1
    t_order();                  // R1 R2
    t_rate(1.8, "R3");          // read clock faster: IDLE insertion
    t_rate(2.2, "R4");          // write clock faster: IDLE deletion
    t_fault(1.8, 1, "R7", "R5"); // underflow then comma recenter
    t_fault(2.2, 2, "R8", "R6"); // overflow then word-sync recenter
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule